// File: doc/BRIEF.md
# Manual Serial Pin Command Engine

This block lets software drive the pins of a serial link to a companion chip one action at a time. Each word written to the command input is decoded into a single bus action. The action is one of: pull chip-select low, release chip-select high, run one single-lane output bit cycle, or run one single-lane input bit cycle. An input cycle stores the returned bit in a readback register. Output and input cycles each produce exactly one serial clock pulse.

The engine owns the pins only while two controls are both high: a manual-enable bit and a mux-select bit that takes the pins away from the automatic transfer path. Its main use is to send the slave-reset pattern. That pattern is chip-select low, one output cycle, chip-select high, then four output cycles with chip-select high. The slave counts those four trailing clock edges and restarts its interface. After that, both controls are cleared and the pins go back to the automatic path.

Top module: `man_serial_cmd`

## Requirements
- R1: A command is taken only on a cycle where `cmd_we` is 1, `cmd_word[13]` (the write flag) is 1, and `man_en` and `mux_sel` are both 1. Any other write leaves the pins, `busy` and `rd_bit` unchanged.
- R2: One clock after `man_en` or `mux_sel` is low, the outputs are idle: `spi_csn`=1, `spi_sck`=0, `spi_mosi`=0 and `busy`=0. A bit cycle that was running is abandoned.
- R3: The opcode is `cmd_word[11:8]`. Opcode 0x1 drives `spi_csn` low and opcode 0x0 drives it high. The new level appears in the cycle after the accepting edge, and `busy` is not raised.
- R4: Opcode 0x8 is an output cycle. For 2*HALF_CYC cycles after the accepting edge, `busy`=1 and `spi_mosi`=`cmd_word[0]`. During that window `spi_sck` is 0 for the first HALF_CYC cycles and 1 for the last HALF_CYC cycles. Afterwards `busy`=0 and `spi_sck`=0.
- R5: Opcode 0xC is an input cycle with the same clock timing as R4 and `spi_mosi`=0. `spi_miso` is sampled into `rd_bit` at the edge where `spi_sck` rises. `rd_bit` changes at no other time.
- R6: A command with the write flag set that arrives while `busy` is 1 is dropped. `cmd_rejected` is 1 for the following cycle only, and the pins are unaffected.
- R7: Any other opcode, including 0x9 and 0xD (the dual-lane cycles, which are not supported), causes no pin activity and no `busy` and no `cmd_rejected`.
- R8: The command sequence 0x1, 0x8, 0x0, 0x8, 0x8, 0x8, 0x8 gives a chip-select low window with one clock pulse, followed by four clock pulses with chip-select high. This is the pattern a slave uses to reset its interface.
- R9: After reset, `spi_csn`=1, `spi_sck`=0, `spi_mosi`=0, `busy`=0, `cmd_rejected`=0 and `rd_bit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| man_en | input | 1 | Manual command mode enable |
| mux_sel | input | 1 | Routes the serial pins to this engine |
| cmd_we | input | 1 | Command write strobe |
| cmd_word | input | 16 | Command: bit 13 write flag, bits 11:8 opcode, bit 0 data |
| spi_miso | input | 1 | Serial data from the companion chip |
| spi_csn | output | 1 | Chip-select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the companion chip |
| busy | output | 1 | A bit cycle is in progress |
| cmd_rejected | output | 1 | One-cycle pulse: a command arrived while busy |
| rd_bit | output | 1 | Last bit captured by an input cycle |

## Verification
The hardest case to reach is a control change that lands in the middle of a bit cycle. Two variants matter: a command arriving while the clock pulse is still running, and the mux being pulled away halfway through the pulse. The stimulus covers the first by writing a chip-select command on the cycle right after an output command was accepted, then checking that chip-select did not move. It covers the second by dropping `mux_sel` during the high half of a cycle. A behavioural slave in the bench counts clock pulses with chip-select high and must flag its reset after the trailing four cycles. Random command mixes, with random data and return bits, run between these directed cases.

// File: rtl/mse_pkg.sv
package mse_pkg;
  localparam int CMD_W    = 16;
  localparam int WR_FLAG  = 13;
  localparam int OP_LSB   = 8;
  localparam int OP_W     = 4;

  localparam logic [OP_W-1:0] OPC_CS_HIGH = 4'h0;
  localparam logic [OP_W-1:0] OPC_CS_LOW  = 4'h1;
  localparam logic [OP_W-1:0] OPC_OUT_1L  = 4'h8;
  localparam logic [OP_W-1:0] OPC_IN_1L   = 4'hC;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_CS_HIGH,
    ACT_CS_LOW,
    ACT_SHIFT_OUT,
    ACT_SHIFT_IN
  } act_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH
  } phase_e;
endpackage

// File: rtl/mse_decode.sv
module mse_decode
  import mse_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output logic             is_write,
  output act_e             act,
  output logic             dbit
);
  logic [OP_W-1:0] op;

  always_comb begin
    op       = cmd[OP_LSB +: OP_W];
    is_write = cmd[WR_FLAG];
    dbit     = cmd[0];
    act      = ACT_NONE;
    if (is_write) begin
      case (op)
        OPC_CS_HIGH: act = ACT_CS_HIGH;
        OPC_CS_LOW:  act = ACT_CS_LOW;
        OPC_OUT_1L:  act = ACT_SHIFT_OUT;
        OPC_IN_1L:   act = ACT_SHIFT_IN;
        default:     act = ACT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mse_bit_timer.sv
module mse_bit_timer
  import mse_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start,
  output logic busy,
  output logic sck,
  output logic rise
);
  localparam int CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sck_q, sck_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    sck_d = sck_q;
    rise  = 1'b0;
    if (!enable) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
      sck_d = 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_d  = PH_LOW;
          cnt_d = '0;
        end
        PH_LOW: if (cnt_q == LAST) begin
          ph_d  = PH_HIGH;
          cnt_d = '0;
          sck_d = 1'b1;
          rise  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        PH_HIGH: if (cnt_q == LAST) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
          sck_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        default: begin
          ph_d  = PH_IDLE;
          sck_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign busy = (ph_q != PH_IDLE);
  assign sck  = sck_q;
endmodule

// File: rtl/man_serial_cmd.sv
module man_serial_cmd
  import mse_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             man_en,
  input  logic             mux_sel,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             spi_miso,
  output logic             spi_csn,
  output logic             spi_sck,
  output logic             spi_mosi,
  output logic             busy,
  output logic             cmd_rejected,
  output logic             rd_bit
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic owned, is_write, dbit, take, go, rise, tmr_busy;
  act_e act;

  assign owned = man_en & mux_sel;

  mse_decode u_dec (
    .cmd      (cmd_word),
    .is_write (is_write),
    .act      (act),
    .dbit     (dbit)
  );

  assign take = cmd_we & is_write & owned;
  assign go   = take & ~tmr_busy;

  mse_bit_timer #(.HALF_CYC(HALF_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .enable (owned),
    .start  (go & ((act == ACT_SHIFT_OUT) | (act == ACT_SHIFT_IN))),
    .busy   (tmr_busy),
    .sck    (spi_sck),
    .rise   (rise)
  );

  logic csn_q, csn_d, mosi_q, mosi_d, rd_q, rd_d, in_q, in_d, rej_q, rej_d;

  always_comb begin
    csn_d  = csn_q;
    mosi_d = mosi_q;
    in_d   = in_q;
    rd_d   = rd_q;
    rej_d  = take & tmr_busy;
    if (!owned) begin
      csn_d  = 1'b1;
      mosi_d = 1'b0;
      in_d   = 1'b0;
    end else begin
      if (rise && in_q) rd_d = spi_miso;
      if (go) begin
        case (act)
          ACT_CS_HIGH:   csn_d = 1'b1;
          ACT_CS_LOW:    csn_d = 1'b0;
          ACT_SHIFT_OUT: begin mosi_d = dbit; in_d = 1'b0; end
          ACT_SHIFT_IN:  begin mosi_d = 1'b0; in_d = 1'b1; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      csn_q  <= 1'b1;
      mosi_q <= 1'b0;
      in_q   <= 1'b0;
      rd_q   <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      csn_q  <= csn_d;
      mosi_q <= mosi_d;
      in_q   <= in_d;
      rd_q   <= rd_d;
      rej_q  <= rej_d;
    end
  end

  assign spi_csn      = csn_q;
  assign spi_mosi     = mosi_q;
  assign busy         = tmr_busy;
  assign cmd_rejected = rej_q;
  assign rd_bit       = rd_q;
endmodule

// File: rtl/mse_checker.sv
module mse_checker (
  input logic clk,
  input logic rst_n,
  input logic man_en,
  input logic mux_sel,
  input logic spi_csn,
  input logic spi_sck,
  input logic spi_mosi,
  input logic busy,
  input logic cmd_rejected,
  input logic rd_bit
);
  a_r2_release_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !(man_en && mux_sel) |=> (spi_csn && !spi_sck && !spi_mosi && !busy));

  a_r4_sck_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> busy);

  a_r4_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));

  a_r5_rd_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_bit) |-> $rose(spi_sck));

  a_r6_reject_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rejected |-> $past(busy));

  a_r3_csn_quiet_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(spi_csn));
endmodule

bind man_serial_cmd mse_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .man_en       (man_en),
  .mux_sel      (mux_sel),
  .spi_csn      (spi_csn),
  .spi_sck      (spi_sck),
  .spi_mosi     (spi_mosi),
  .busy         (busy),
  .cmd_rejected (cmd_rejected),
  .rd_bit       (rd_bit)
);

// File: tb/man_serial_cmd_tb.sv
module man_serial_cmd_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 2;

  logic clk = 1'b0;
  logic rst_n, man_en, mux_sel, cmd_we, spi_miso;
  logic [15:0] cmd_word;
  logic spi_csn, spi_sck, spi_mosi, busy, cmd_rejected, rd_bit;

  int n_run = 0;
  int n_fail = 0;
  bit exp_csn;
  bit exp_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  man_serial_cmd #(.HALF_CYC(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .man_en(man_en), .mux_sel(mux_sel),
    .cmd_we(cmd_we), .cmd_word(cmd_word), .spi_miso(spi_miso),
    .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .busy(busy), .cmd_rejected(cmd_rejected), .rd_bit(rd_bit)
  );

  // behavioural slave: counts clock pulses with chip-select high
  bit sck_prev = 0, csn_prev = 1, lo_seen = 0, slv_reset = 0;
  int hi_cnt = 0;
  always @(negedge clk) begin
    if (csn_prev && !spi_csn) begin lo_seen = 0; hi_cnt = 0; slv_reset = 0; end
    if (!csn_prev && spi_csn) hi_cnt = 0;
    if (spi_sck && !sck_prev) begin
      if (!spi_csn) lo_seen = 1;
      else begin
        hi_cnt++;
        if (lo_seen && hi_cnt == 4) slv_reset = 1;
      end
    end
    sck_prev = spi_sck;
    csn_prev = spi_csn;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit wr, input logic [3:0] op, input bit d);
    return {2'b00, wr, 1'b0, op, 7'b0, d};
  endfunction

  function automatic int kind(input logic [3:0] op);
    case (op)
      4'h0: return 1;
      4'h1: return 2;
      4'h8: return 3;
      4'hC: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic pulse(input logic [15:0] w);
    cmd_word = w; cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0; cmd_word = '0;
  endtask

  // issues a write-flagged command and checks it against the requirements
  task automatic do_cmd(input logic [3:0] op, input bit d, input bit miso);
    int k;
    k = kind(op);
    spi_miso = miso;
    pulse(mk(1'b1, op, d));
    if (k == 1 || k == 2) begin
      exp_csn = (k == 1);
      chk("R3 csn level", spi_csn, exp_csn);
      chk("R3 no busy", busy, 0);
    end else if (k == 3 || k == 4) begin
      for (int i = 0; i < 2*H; i++) begin
        if (i == 0 || i == H) begin
          chk((k == 3) ? "R4 sck phase" : "R5 sck phase", spi_sck, (i >= H) ? 1 : 0);
          chk((k == 3) ? "R4 mosi data" : "R5 mosi zero", spi_mosi, (k == 3) ? d : 0);
          chk("R4 busy in cycle", busy, 1);
        end
        @(negedge clk);
      end
      chk("R4 busy end", busy, 0);
      chk("R4 sck end", spi_sck, 0);
      if (k == 4) exp_rd = miso;
      chk("R5 rd_bit", rd_bit, exp_rd);
    end else begin
      chk("R7 no busy", busy, 0);
      chk("R7 no sck", spi_sck, 0);
      chk("R7 no reject", cmd_rejected, 0);
      chk("R7 csn kept", spi_csn, exp_csn);
    end
    chk("R1 csn track", spi_csn, exp_csn);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] ops [7] = '{4'h0, 4'h1, 4'h8, 4'hC, 4'h9, 4'hD, 4'h5};
    void'($urandom(32'd1234));
    rst_n = 0; man_en = 0; mux_sel = 0; cmd_we = 0; cmd_word = '0; spi_miso = 0;
    exp_csn = 1; exp_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R9 csn", spi_csn, 1);
    chk("R9 sck", spi_sck, 0);
    chk("R9 mosi", spi_mosi, 0);
    chk("R9 busy", busy, 0);
    chk("R9 rejected", cmd_rejected, 0);
    chk("R9 rd", rd_bit, 0);

    // R1: not owned, command ignored
    man_en = 1; mux_sel = 0;
    pulse(mk(1'b1, 4'h1, 1'b0));
    chk("R1 ignored without mux", spi_csn, 1);
    mux_sel = 1;
    pulse(mk(1'b0, 4'h1, 1'b0));
    chk("R1 ignored without write flag", spi_csn, 1);
    pulse(mk(1'b0, 4'h8, 1'b1));
    chk("R1 no cycle without write flag", busy, 0);

    // R8: slave reset pattern
    do_cmd(4'h1, 0, 0);
    do_cmd(4'h8, 1, 0);
    do_cmd(4'h0, 0, 0);
    chk("R8 slave not yet reset", slv_reset, 0);
    for (int j = 0; j < 4; j++) do_cmd(4'h8, 0, 0);
    chk("R8 slave reset seen", slv_reset, 1);

    // R5 both capture values
    do_cmd(4'hC, 0, 1);
    do_cmd(4'hC, 0, 0);

    // R6: command while busy
    pulse(mk(1'b1, 4'h8, 1'b1));
    pulse(mk(1'b1, 4'h1, 1'b0));
    chk("R6 rejected pulse", cmd_rejected, 1);
    chk("R6 csn untouched", spi_csn, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", cmd_rejected, 0);
    repeat (2*H) @(negedge clk);
    chk("R6 busy done", busy, 0);

    // R2: mux pulled mid cycle
    do_cmd(4'h1, 0, 0);
    spi_miso = 1;
    pulse(mk(1'b1, 4'hC, 1'b0));
    repeat (H) @(negedge clk);
    chk("R2 sck high before drop", spi_sck, 1);
    mux_sel = 0;
    @(negedge clk);
    chk("R2 csn released", spi_csn, 1);
    chk("R2 sck low", spi_sck, 0);
    chk("R2 busy clear", busy, 0);
    chk("R2 mosi low", spi_mosi, 0);
    exp_rd = 1; exp_csn = 1;
    mux_sel = 1;
    @(negedge clk);

    // random mix
    for (int n = 0; n < 60; n++) begin
      int idx;
      idx = $urandom_range(0, 6);
      do_cmd(ops[idx], 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule